// File: doc/BRIEF.md
# Twisted GFSR Bit Generator Bank

This block holds ten independent, seeded pseudo-random bit sources. Each source is a twisted generalized feedback shift register whose 16-bit state words carry two interlaced registers, one with 8-bit words on the even bit positions and one with 7-bit words on the odd positions, or the reverse. Each source keeps a 7-word state array and a 32-bit step count. A step strobe advances exactly one source, chosen by a 4-bit select. That source rewrites one word of its array and returns the two lowest bits of the new word as a pair of pseudo-random bits.

A load strobe, and reset, put every source back into its seeded state. A second select addresses a combinational read port that returns the chosen source's step count, less its starting value, so that a following stage can serialize it. Seeds, twist constants and tap offsets are parameters.

Control is a two-state machine. `ST_IDLE` means no result is pending. `ST_EMIT` means the result of last cycle's step is on the outputs. An accepted step moves to `ST_EMIT` (transition *accept*). A cycle without an accepted step moves to `ST_IDLE` (transition *drain*). A load forces `ST_IDLE` (transition *restore*). Back-to-back steps keep the machine in `ST_EMIT`.

Top module: `tgfsr_bank`

## Requirements
- R1: After reset, `bits_valid` is 0 and `rd_count` reads 0 for every source.
- R2: A step accepted at a clock edge raises `bits_valid` for the following cycle only, unless another step is accepted at the next edge.
- R3: Stepping source g first adds one to its count K. It then writes word p = K mod 7 with X[(p+M) mod 7] XOR (X[p] shifted right by 2) XOR A[X[p] bits 1:0], where X[p] on the right-hand side is the old word.
- R4: The default tap offsets M for sources 0 to 9 are 1, 1, 3, 3, 4, 4, 5, 5, 6, 6.
- R5: `bit_k1` is bit 0 and `bit_k2` is bit 1 of the word just written, both registered and valid while `bits_valid` is 1.
- R6: A step changes neither the count nor the later output sequence of any unselected source.
- R7: A step with a select of 10 to 15 advances no source and does not raise `bits_valid`.
- R8: A load restores every seed word and sets every count back to its start value of 6. The read port then returns 0 for all sources. A load wins over a step in the same cycle, and no valid pulse follows.
- R9: On load, the unused bit of each word is cleared in the seeds and the twist constants: bit 15 for odd sources, bit 14 for even sources. That bit stays 0 afterwards.
- R10: `rd_count` returns K - 6 of the source chosen by `rd_sel`, and 0 for a select of 10 to 15.
- R11: Consecutive steps, one per cycle, each give a result in the next cycle, in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; acts like a load |
| load | input | 1 | Restore all sources to their seeded state |
| step | input | 1 | Advance the selected source |
| gen_sel | input | 4 | Source to advance |
| bits_valid | output | 1 | Result of the previous cycle's step is present |
| bit_k1 | output | 1 | Bit 0 of the new word |
| bit_k2 | output | 1 | Bit 1 of the new word |
| rd_sel | input | 4 | Source whose count is read |
| rd_count | output | 32 | Selected source's count less 6 |

## Verification
The bench passes in its own seeds and twist constants, with both top bits set in every seed word. A software model of the recurrence then diverges from the outputs if the masking is missing. Four select patterns are used. A round robin over all 16 select codes separates the ten real sources from the ignored codes. Long bursts on one source carry the word pointer through many wraps and check the tap offset of each source. A pseudo-random select sequence with idle gaps shows that unselected sources keep their state and that the valid pulse ends. A load issued together with a step checks that the load takes priority and that the sequence starts over from the seeds.

// File: rtl/tgfsr_pkg.sv
package tgfsr_pkg;

    localparam int DEF_NGEN   = 10;
    localparam int DEF_NWORDS = 7;
    localparam int DEF_WW     = 16;
    localparam int TAP_W      = 4;

    typedef enum logic {
        ST_IDLE,
        ST_EMIT
    } bank_state_t;

    // Position of the unused bit in each word (7-bit half of the pair).
    function automatic int pad_bit(input int g, input int ww);
        return (g % 2 == 1) ? ww - 1 : ww - 2;
    endfunction

    // Default seed words, computed arithmetically.
    function automatic logic [DEF_NGEN*DEF_NWORDS*DEF_WW-1:0] def_seeds();
        logic [DEF_NGEN*DEF_NWORDS*DEF_WW-1:0] r;
        logic [31:0] v;
        r = '0;
        for (int g = 0; g < DEF_NGEN; g++) begin
            for (int w = 0; w < DEF_NWORDS; w++) begin
                v = 32'((g * DEF_NWORDS + w + 1) * 40503);
                r[(g*DEF_NWORDS+w)*DEF_WW +: DEF_WW] = v[15:0] ^ v[31:16];
            end
        end
        return r;
    endfunction

    // Twist table: entry 3 given, entries 1 and 2 keep one interlaced half each.
    function automatic logic [DEF_NGEN*4*DEF_WW-1:0] def_twists();
        logic [DEF_NGEN*4*DEF_WW-1:0] r;
        logic [15:0] a3;
        r = '0;
        for (int g = 0; g < DEF_NGEN; g++) begin
            case (g)
                0:       a3 = 16'h9EC1;
                1:       a3 = 16'h720F;
                2:       a3 = 16'h9F56;
                3:       a3 = 16'h713A;
                4:       a3 = 16'hB44B;
                5:       a3 = 16'h674A;
                6:       a3 = 16'h9B52;
                7:       a3 = 16'h61B9;
                8:       a3 = 16'h9F56;
                default: a3 = 16'h713A;
            endcase
            r[(g*4+1)*DEF_WW +: DEF_WW] = a3 & 16'h5555;
            r[(g*4+2)*DEF_WW +: DEF_WW] = a3 & 16'hAAAA;
            r[(g*4+3)*DEF_WW +: DEF_WW] = a3;
        end
        return r;
    endfunction

    // Tap offsets 1,1,3,3,4,4,5,5,6,6.
    function automatic logic [DEF_NGEN*TAP_W-1:0] def_taps();
        logic [DEF_NGEN*TAP_W-1:0] r;
        int t;
        r = '0;
        for (int g = 0; g < DEF_NGEN; g++) begin
            t = (g < 2) ? 1 : (g / 2) + 2;
            r[g*TAP_W +: TAP_W] = TAP_W'(t);
        end
        return r;
    endfunction

endpackage

// File: rtl/tgfsr_gen.sv
module tgfsr_gen #(
    parameter int WW     = 16,
    parameter int NWORDS = 7,
    parameter int CNT_W  = 32,
    parameter int TAP    = 1,
    parameter int PAD    = 14,
    parameter logic [NWORDS*WW-1:0] SEED  = '0,
    parameter logic [4*WW-1:0]      TWIST = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             adv,
    output logic [1:0]       nxt_bits,
    output logic [CNT_W-1:0] count
);
    localparam int PTR_W = $clog2(NWORDS);
    localparam logic [WW-1:0]    KEEP     = ~(WW'(1) << PAD);
    localparam logic [CNT_W-1:0] CNT_BASE = CNT_W'(NWORDS - 1);
    localparam logic [PTR_W-1:0] PTR_BASE = PTR_W'(NWORDS - 1);

    logic [WW-1:0]    words [NWORDS];
    logic [PTR_W-1:0] ptr;
    logic [PTR_W-1:0] ptr_n;
    logic [PTR_W:0]   tap_sum;
    logic [PTR_W-1:0] tap_idx;
    logic [WW-1:0]    old_w;
    logic [WW-1:0]    new_w;
    logic             pad_any;

    // Write pointer tracks count mod NWORDS without a wide divider.
    always_comb begin
        ptr_n   = (ptr == PTR_BASE) ? '0 : ptr + PTR_W'(1);
        tap_sum = {1'b0, ptr_n} + (PTR_W+1)'(TAP);
        if (tap_sum >= (PTR_W+1)'(NWORDS))
            tap_sum = tap_sum - (PTR_W+1)'(NWORDS);
        tap_idx = tap_sum[PTR_W-1:0];
        old_w   = words[ptr_n];
        new_w   = (words[tap_idx] ^ (old_w >> 2)
                   ^ TWIST[old_w[1:0]*WW +: WW]) & KEEP;
        nxt_bits = new_w[1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NWORDS; i++)
                words[i] <= SEED[i*WW +: WW] & KEEP;
            count <= CNT_BASE;
            ptr   <= PTR_BASE;
        end else if (load) begin
            for (int i = 0; i < NWORDS; i++)
                words[i] <= SEED[i*WW +: WW] & KEEP;
            count <= CNT_BASE;
            ptr   <= PTR_BASE;
        end else if (adv) begin
            words[ptr_n] <= new_w;
            count        <= count + CNT_W'(1);
            ptr          <= ptr_n;
        end
    end

    always_comb begin
        pad_any = 1'b0;
        for (int i = 0; i < NWORDS; i++)
            pad_any = pad_any | words[i][PAD];
    end

    // R3: an accepted step adds exactly one to the count
    p_count_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !load) |=> (count == $past(count) + CNT_W'(1)));

    // R6: without a step or load the count is held
    p_hold_unsel_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!adv && !load) |=> $stable(count));

    // R8: load returns the count to its start value
    p_load_count_r8: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (count == CNT_BASE));

    // R9: the unused bit of every word stays clear
    p_pad_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !pad_any);

endmodule

// File: rtl/tgfsr_bank.sv
module tgfsr_bank
    import tgfsr_pkg::*;
#(
    parameter int NGEN   = DEF_NGEN,
    parameter int NWORDS = DEF_NWORDS,
    parameter int WW     = DEF_WW,
    parameter int CNT_W  = 32,
    parameter logic [NGEN*NWORDS*WW-1:0] SEEDS  = def_seeds(),
    parameter logic [NGEN*4*WW-1:0]      TWISTS = def_twists(),
    parameter logic [NGEN*TAP_W-1:0]     TAPS   = def_taps()
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             step,
    input  logic [3:0]       gen_sel,
    output logic             bits_valid,
    output logic             bit_k1,
    output logic             bit_k2,
    input  logic [3:0]       rd_sel,
    output logic [CNT_W-1:0] rd_count
);
    localparam int SEL_W = 4;
    localparam logic [CNT_W-1:0] CNT_BASE = CNT_W'(NWORDS - 1);

    bank_state_t      state, state_n;
    logic             sel_ok;
    logic             rd_ok;
    logic             accept;
    logic [1:0]       kbits;
    logic [1:0]       gen_bits  [NGEN];
    logic [CNT_W-1:0] gen_count [NGEN];

    assign sel_ok = (int'(gen_sel) < NGEN);
    assign rd_ok  = (int'(rd_sel) < NGEN);
    assign accept = step && !load && sel_ok;

    for (genvar g = 0; g < NGEN; g++) begin : g_src
        tgfsr_gen #(
            .WW    (WW),
            .NWORDS(NWORDS),
            .CNT_W (CNT_W),
            .TAP   (int'(TAPS[g*TAP_W +: TAP_W])),
            .PAD   (pad_bit(g, WW)),
            .SEED  (SEEDS[g*NWORDS*WW +: NWORDS*WW]),
            .TWIST (TWISTS[g*4*WW +: 4*WW])
        ) u_gen (
            .clk     (clk),
            .rst_n   (rst_n),
            .load    (load),
            .adv     (accept && (gen_sel == SEL_W'(g))),
            .nxt_bits(gen_bits[g]),
            .count   (gen_count[g])
        );
    end

    // Next-state logic
    always_comb begin
        state_n = state;
        unique case (state)
            ST_IDLE: state_n = accept ? ST_EMIT : ST_IDLE;
            ST_EMIT: state_n = accept ? ST_EMIT : ST_IDLE;
        endcase
        if (load)
            state_n = ST_IDLE;
    end

    // State register and result register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            kbits <= 2'b00;
        end else begin
            state <= state_n;
            if (accept)
                kbits <= gen_bits[gen_sel];
        end
    end

    // Outputs
    always_comb begin
        bits_valid = (state == ST_EMIT);
        bit_k1     = kbits[0];
        bit_k2     = kbits[1];
        rd_count   = rd_ok ? (gen_count[rd_sel] - CNT_BASE) : '0;
    end

    // R2: an accepted step gives a valid result in the next cycle
    p_valid_after_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load && sel_ok) |=> bits_valid);

    // R2: without an accepted step the valid pulse ends
    p_valid_drops_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(step && sel_ok) |=> !bits_valid);

    // R7: out-of-range select never produces a result
    p_bad_sel_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !sel_ok) |=> !bits_valid);

    // R8: load wins over step
    p_load_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> !bits_valid);

endmodule

// File: tb/tgfsr_bank_tb.sv
module tgfsr_bank_tb;
    localparam int PERIOD = 10;
    localparam int NG = 10;
    localparam int NW = 7;
    localparam int WW = 16;

    function automatic logic [NG*NW*WW-1:0] tb_seeds();
        logic [NG*NW*WW-1:0] r;
        logic [31:0] v;
        for (int g = 0; g < NG; g++)
            for (int w = 0; w < NW; w++) begin
                v = 32'((g * 13 + w * 5 + 3) * 2654435);
                r[(g*NW+w)*WW +: WW] = v[23:8] | 16'hC000;
            end
        return r;
    endfunction

    function automatic logic [15:0] tb_tw(input int g, input int i);
        logic [15:0] b;
        b = 16'h6B4D ^ 16'(g * 16'h1357);
        case (i)
            0:       return 16'h0000;
            1:       return b & 16'h5555;
            2:       return b & 16'hAAAA;
            default: return b;
        endcase
    endfunction

    function automatic logic [NG*4*WW-1:0] tb_twists();
        logic [NG*4*WW-1:0] r;
        for (int g = 0; g < NG; g++)
            for (int i = 0; i < 4; i++)
                r[(g*4+i)*WW +: WW] = tb_tw(g, i);
        return r;
    endfunction

    localparam logic [NG*NW*WW-1:0] SEEDS  = tb_seeds();
    localparam logic [NG*4*WW-1:0]  TWISTS = tb_twists();

    logic        clk = 0;
    logic        rst_n = 0;
    logic        load = 0;
    logic        step = 0;
    logic [3:0]  gen_sel = 0;
    logic [3:0]  rd_sel = 0;
    logic        bits_valid, bit_k1, bit_k2;
    logic [31:0] rd_count;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    logic [15:0] mx [NG][NW];
    int          mk [NG];

    always #(PERIOD/2) clk = ~clk;

    tgfsr_bank #(.SEEDS(SEEDS), .TWISTS(TWISTS)) u_dut (
        .clk(clk), .rst_n(rst_n), .load(load), .step(step),
        .gen_sel(gen_sel), .bits_valid(bits_valid), .bit_k1(bit_k1),
        .bit_k2(bit_k2), .rd_sel(rd_sel), .rd_count(rd_count)
    );

    function automatic logic [15:0] keep_mask(input int g);
        return (g % 2 == 1) ? 16'h7FFF : 16'hBFFF;
    endfunction

    function automatic int tap_of(input int g);   // R4 tap table
        case (g)
            0, 1:    return 1;
            2, 3:    return 3;
            4, 5:    return 4;
            6, 7:    return 5;
            default: return 6;
        endcase
    endfunction

    task automatic model_reset();
        for (int g = 0; g < NG; g++) begin
            mk[g] = 6;
            for (int w = 0; w < NW; w++)
                mx[g][w] = SEEDS[(g*NW+w)*WW +: WW] & keep_mask(g);
        end
    endtask

    task automatic model_step(input int g, output logic [1:0] kb);
        int p;
        logic [15:0] o, nw;
        mk[g] = mk[g] + 1;
        p = mk[g] % NW;
        o = mx[g][p];
        nw = (mx[g][(p + tap_of(g)) % NW] ^ (o >> 2)
              ^ (tb_tw(g, int'(o[1:0])) & keep_mask(g))) & keep_mask(g);
        mx[g][p] = nw;
        kb = nw[1:0];
    endtask

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Call at a falling edge; returns at the next falling edge.
    task automatic do_step(input int sel, input string req);
        logic [1:0] kb;
        bit v;
        step = 1; gen_sel = 4'(sel);
        @(posedge clk); @(negedge clk);
        v = (sel < NG);
        chk(bits_valid == v, {req, " valid"}, longint'(bits_valid), longint'(v));
        if (v) begin
            model_step(sel, kb);
            chk({bit_k2, bit_k1} == kb, {req, " bits"}, longint'({bit_k2, bit_k1}), longint'(kb));
        end
        step = 0;
    endtask

    task automatic check_counts(input string req);   // R10
        for (int g = 0; g < 16; g++) begin
            rd_sel = 4'(g);
            #1;
            if (g < NG)
                chk(rd_count == 32'(mk[g] - 6), req, longint'(rd_count), longint'(mk[g] - 6));
            else
                chk(rd_count == 0, req, longint'(rd_count), 0);
        end
        @(negedge clk);
    endtask

    initial begin
        #(PERIOD * 100000);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [15:0] lfsr;
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        // R1: reset state
        chk(bits_valid == 0, "R1 valid", longint'(bits_valid), 0);
        check_counts("R1 count");

        // Round robin over all select codes (R7 for 10..15, R11 back to back)
        for (int lap = 0; lap < 3; lap++)
            for (int s = 0; s < 16; s++)
                do_step(s, (s < NG) ? "R5 R11 rr" : "R7 rr");
        check_counts("R7 R10 after rr");

        // Bursts per source: pointer wraps, per-source taps (R3, R4, R9)
        for (int g = 0; g < NG; g++) begin
            for (int n = 0; n < 60; n++)
                do_step(g, "R3 R4 R9 burst");
            @(posedge clk); @(negedge clk);
            chk(bits_valid == 0, "R2 pulse end", longint'(bits_valid), 0);
        end
        check_counts("R10 after bursts");

        // Pseudo-random selection with idle gaps (R6)
        lfsr = 16'hACE1;
        for (int n = 0; n < 500; n++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            if (lfsr[7:5] == 3'd0) begin
                @(posedge clk); @(negedge clk);
                chk(bits_valid == 0, "R2 gap", longint'(bits_valid), 0);
            end else begin
                do_step(int'(lfsr[3:0]), "R6 mixed");
            end
        end
        check_counts("R6 R10 after mixed");

        // Load together with step: load wins, everything restarts (R8)
        load = 1; step = 1; gen_sel = 4'd3;
        @(posedge clk); @(negedge clk);
        chk(bits_valid == 0, "R8 load wins", longint'(bits_valid), 0);
        load = 0; step = 0;
        model_reset();
        check_counts("R8 count restored");
        for (int n = 0; n < 20; n++)
            do_step(3, "R8 restart");
        for (int n = 0; n < 20; n++)
            do_step(8, "R8 restart");
        check_counts("R10 final");

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule